// File: doc/BRIEF.md
# Over-temperature trip monitor

This block watches four on-die temperature readings (CPU, GPU, memory and PLL) and raises a shutdown request when one of them climbs above its programmed limit. Each reading is a 16-bit sign-magnitude word with half-degree resolution. The limits are signed whole-degree bytes held in a 32-bit control register. One limit serves the CPU, one is shared by GPU and memory, and one general limit covers the PLL reading. Every cycle, each reading is converted to half-degree units and compared with twice its limit.

A set trip request is sticky. Once any enabled comparison fires, the trip flag and the per-source bits stay set until reset, even after the temperature falls. This lets the reset logic downstream sample the request at leisure, and lets software see afterwards which source caused it. Clearing the global enable bit stops new trip bits from being set. It does not clear bits that are already set.

Top module: `overtemp_trip_monitor`

## Requirements
- R1: A reading word holds the integer degree magnitude in bits 15:8, a half-degree flag in bit 7 and a sign flag in bit 0 (1 = negative). Its value in half degrees is ±(2·magnitude + half flag).
- R2: Control bits 7:0 hold the general limit, bits 15:8 the CPU limit and bits 23:16 the GPU/memory limit. Each is a signed two's-complement byte in whole degrees. Bit 28 is the enable. All other bits are discarded and read back as zero on `cfg_rdata`.
- R3: A reading trips only when it is strictly greater than its limit. A reading equal to the limit does not trip.
- R4: While control bit 28 is clear, no trip bit becomes set, whatever the readings are.
- R5: `temp_cg` carries the CPU reading in bits 31:16 and the GPU reading in bits 15:0. `temp_mp` carries the memory reading in bits 31:16 and the PLL reading in bits 15:0. The PLL reading is compared with the general limit.
- R6: `trip_src` bit 0 is CPU, bit 1 is GPU, bit 2 is memory and bit 3 is PLL. `trip` is high exactly when some `trip_src` bit is set.
- R7: Trip bits are sticky. They accumulate new sources, and only reset clears them.
- R8: After reset, all three limits are 105 degrees and the enable is clear. `cfg_rdata` reads 0x0069_6969, and `trip` and `trip_src` are zero.
- R9: A negative-zero reading counts as zero. A negative limit makes every non-negative reading trip.
- R10: A control write becomes effective at the next clock edge. A trip is registered at the clock edge that follows the comparison that caused it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register readback |
| temp_cg | input | 32 | CPU reading (31:16) and GPU reading (15:0) |
| temp_mp | input | 32 | Memory reading (31:16) and PLL reading (15:0) |
| trip | output | 1 | Sticky trip request |
| trip_src | output | 4 | Sticky per-source trip bits |

## Verification
The bench sweeps reading magnitudes at and around every limit, with both half-degree states, both signs and several negative and extreme limits. It computes the expected trip arithmetically. A design that compared with `>=`, dropped the half bit or took the sign as two's complement would miscount at exactly the equal and half-above points. The bench checks each source in isolation against distinct limits, so a design that mixed up the packing of the two input words or gave the PLL the wrong limit would set the wrong `trip_src` bit. It also drives write-and-heat in the same cycle, cools after a trip, and disables the block while hot. These cases catch a design that is a cycle early, clears its flags when the temperature drops, or keeps latching while disabled.

// File: rtl/otm_pkg.sv
package otm_pkg;
   localparam int NUM_CH  = 4;   // 0 cpu, 1 gpu, 2 mem, 3 pll
   localparam int NUM_GRP = 3;   // threshold groups

   typedef enum logic [1:0] {
      GRP_GEN = 2'd0,
      GRP_CPU = 2'd1,
      GRP_GM  = 2'd2
   } grp_e;

   function automatic grp_e ch_group(input int ch);
      case (ch)
         0:       return GRP_CPU;
         1, 2:    return GRP_GM;
         default: return GRP_GEN;
      endcase
   endfunction
endpackage

// File: rtl/otm_ctrl_reg.sv
module otm_ctrl_reg
   import otm_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int THR_W   = 8,
   parameter int EN_BIT  = 28,
   parameter int RST_THR = 105,
   parameter bit RST_EN  = 1'b0
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [DATA_W-1:0]              wr_data,
   output logic [NUM_GRP-1:0][THR_W-1:0]  thr,
   output logic                           en,
   output logic [DATA_W-1:0]              rd_data
);
   localparam int FIELD_TOP = NUM_GRP * THR_W;

   function automatic logic [DATA_W-1:0] keep_mask();
      logic [DATA_W-1:0] m;
      m = '0;
      for (int i = 0; i < FIELD_TOP; i++) m[i] = 1'b1;
      m[EN_BIT] = 1'b1;
      return m;
   endfunction

   localparam logic [DATA_W-1:0] WMASK = keep_mask();

   generate
      if (FIELD_TOP > EN_BIT)
         $error("threshold fields overlap the enable bit");
      if (EN_BIT >= DATA_W)
         $error("enable bit outside register");
      if (RST_THR > (2 ** (THR_W - 1)) - 1 || RST_THR < -(2 ** (THR_W - 1)))
         $error("reset threshold does not fit field");
   endgenerate

   logic [NUM_GRP-1:0][THR_W-1:0] thr_q;
   logic                          en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int g = 0; g < NUM_GRP; g++) thr_q[g] <= THR_W'(RST_THR);
         en_q <= RST_EN;
      end else if (wr_en) begin
         for (int g = 0; g < NUM_GRP; g++) thr_q[g] <= wr_data[g*THR_W +: THR_W];
         en_q <= wr_data[EN_BIT];
      end
   end

   always_comb begin
      rd_data = '0;
      for (int g = 0; g < NUM_GRP; g++) rd_data[g*THR_W +: THR_W] = thr_q[g];
      rd_data[EN_BIT] = en_q;
   end

   assign thr = thr_q;
   assign en  = en_q;

   logic unused_wbits;
   assign unused_wbits = ^(wr_data & ~WMASK);

   AST_WRITE_NEXT_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data == ($past(wr_data) & WMASK)));   // R10

   AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(rd_data));   // R2
endmodule

// File: rtl/otm_reading_cmp.sv
module otm_reading_cmp #(
   parameter int WORD_W        = 16,
   parameter int MAG_LSB       = 8,
   parameter int MAG_W         = 8,
   parameter int HALF_BIT      = 7,
   parameter int SIGN_BIT      = 0,
   parameter int THR_W         = 8,
   parameter bit TRIP_AT_EQUAL = 1'b0
) (
   input  logic [WORD_W-1:0] word,
   input  logic [THR_W-1:0]  thr,
   output logic              hit
);
   localparam int RD_W  = MAG_W + 2;
   localparam int TH_W  = THR_W + 1;
   localparam int CMP_W = ((RD_W > TH_W) ? RD_W : TH_W) + 1;

   generate
      if (MAG_LSB + MAG_W > WORD_W)
         $error("magnitude field exceeds word");
      if (HALF_BIT >= MAG_LSB || SIGN_BIT >= MAG_LSB || HALF_BIT == SIGN_BIT)
         $error("flag bits must sit below the magnitude and be distinct");
   endgenerate

   logic [MAG_W:0]           mag_half;
   logic signed [CMP_W-1:0]  rd_mag;
   logic signed [CMP_W-1:0]  rd_s;
   logic signed [CMP_W-1:0]  th_ext;
   logic signed [CMP_W-1:0]  th_s;

   always_comb begin
      mag_half = {word[MAG_LSB +: MAG_W], word[HALF_BIT]};
      rd_mag   = $signed({{(CMP_W-MAG_W-1){1'b0}}, mag_half});
      rd_s     = word[SIGN_BIT] ? -rd_mag : rd_mag;
      th_ext   = $signed({{(CMP_W-THR_W){thr[THR_W-1]}}, thr});
      th_s     = th_ext <<< 1;
   end

   generate
      if (TRIP_AT_EQUAL) begin : g_ge
         assign hit = (rd_s >= th_s);
      end else begin : g_gt
         assign hit = (rd_s > th_s);
         always_comb begin
            AST_NEG_BELOW_POS: assert (!(hit && word[SIGN_BIT] && !thr[THR_W-1])); // R9
         end
      end
   endgenerate

   logic unused_word;
   assign unused_word = ^word;
endmodule

// File: rtl/otm_trip_latch.sv
module otm_trip_latch #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [N-1:0] hit,
   output logic [N-1:0] src,
   output logic         trip
);
   generate
      if (N < 1) $error("need at least one source");
   endgenerate

   logic [N-1:0] src_q;
   logic         trip_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q  <= '0;
         trip_q <= 1'b0;
      end else begin
         src_q  <= src_q | (en ? hit : '0);
         trip_q <= trip_q | (en & (|hit));
      end
   end

   assign src  = src_q;
   assign trip = trip_q;

   AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((src_q & $past(src_q)) == $past(src_q)));   // R7

   AST_OFF_NO_NEW: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (src_q == $past(src_q)));   // R4

   AST_FLAG_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      trip_q == (src_q != '0));   // R6

   AST_NEW_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_q & ~$past(src_q)) != '0) |-> ($past(en) && ($past(hit) != '0)));   // R10
endmodule

// File: rtl/overtemp_trip_monitor.sv
module overtemp_trip_monitor
   import otm_pkg::*;
#(
   parameter int WORD_W        = 16,
   parameter int THR_W         = 8,
   parameter int EN_BIT        = 28,
   parameter int RST_THR       = 105,
   parameter bit TRIP_AT_EQUAL = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [31:0]         cfg_wdata,
   output logic [31:0]         cfg_rdata,
   input  logic [2*WORD_W-1:0] temp_cg,
   input  logic [2*WORD_W-1:0] temp_mp,
   output logic                trip,
   output logic [NUM_CH-1:0]   trip_src
);
   localparam int ALL_W = NUM_CH * WORD_W;

   generate
      if (WORD_W < 16) $error("reading word too narrow");
   endgenerate

   logic [NUM_GRP-1:0][THR_W-1:0] thr_grp;
   logic                          en;
   logic [ALL_W-1:0]              all_words;
   logic [NUM_CH-1:0]             hit;

   assign all_words = {temp_cg, temp_mp};

   otm_ctrl_reg #(
      .DATA_W (32),
      .THR_W  (THR_W),
      .EN_BIT (EN_BIT),
      .RST_THR(RST_THR),
      .RST_EN (1'b0)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we),
      .wr_data(cfg_wdata),
      .thr    (thr_grp),
      .en     (en),
      .rd_data(cfg_rdata)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      localparam grp_e GRP = ch_group(ch);
      otm_reading_cmp #(
         .WORD_W       (WORD_W),
         .MAG_LSB      (8),
         .MAG_W        (8),
         .HALF_BIT     (7),
         .SIGN_BIT     (0),
         .THR_W        (THR_W),
         .TRIP_AT_EQUAL(TRIP_AT_EQUAL)
      ) u_cmp (
         .word(all_words[(NUM_CH-1-ch)*WORD_W +: WORD_W]),
         .thr (thr_grp[int'(GRP)]),
         .hit (hit[ch])
      );
   end

   otm_trip_latch #(.N(NUM_CH)) u_latch (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en),
      .hit  (hit),
      .src  (trip_src),
      .trip (trip)
   );
endmodule

// File: tb/sim_overtemp_trip_monitor.sv
`timescale 1ns/1ps
module sim_overtemp_trip_monitor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [31:0] temp_cg = '0;
   logic [31:0] temp_mp = '0;
   logic        trip;
   logic [3:0]  trip_src;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #4 clk = ~clk;

   overtemp_trip_monitor u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .temp_cg(temp_cg), .temp_mp(temp_mp),
      .trip(trip), .trip_src(trip_src)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [15:0] mkw(input int mag, input bit half, input bit neg);
      return {mag[7:0], half, 6'b0, neg};
   endfunction

   function automatic int half_val(input logic [15:0] w);
      int m;
      m = int'(w[15:8]) * 2 + int'(w[7]);
      return w[0] ? -m : m;
   endfunction

   function automatic logic [31:0] mkc(input bit en, input int gen, input int cpu, input int gm);
      return {3'b0, en, 4'b0, gm[7:0], cpu[7:0], gen[7:0]};
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cfg_we = 1'b0; temp_cg = '0; temp_mp = '0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [31:0] v);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic heat(input logic [15:0] c, input logic [15:0] g,
                       input logic [15:0] m, input logic [15:0] p);
      temp_cg = {c, g}; temp_mp = {m, p};
      @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R8 reset state
      check("R8 rdata", cfg_rdata, 32'h0069_6969);
      check("R8 trip", {31'b0, trip}, 0);
      check("R8 src", {28'b0, trip_src}, 0);
      // R4 / R8: disabled after reset, hot readings ignored
      heat(mkw(127,1,0), mkw(127,1,0), mkw(127,1,0), mkw(127,1,0));
      @(negedge clk);
      check("R4 disabled at reset", {28'b0, trip_src}, 0);

      // R10: write and heat in the same cycle
      do_reset();
      cfg_we = 1'b1; cfg_wdata = mkc(1, 50, 50, 50);
      temp_cg = {mkw(60,0,0), 16'h0}; temp_mp = '0;
      @(negedge clk);
      cfg_we = 1'b0;
      check("R10 write visible", cfg_rdata, mkc(1, 50, 50, 50));
      check("R10 no trip yet", {28'b0, trip_src}, 0);
      @(negedge clk);
      check("R10 trip next edge", {28'b0, trip_src}, 4'b0001);
      check("R6 flag", {31'b0, trip}, 1);

      // R1 R3 R9 sweep: all channels same word, all groups same limit
      begin
         int tl [7] = '{-128, -1, 0, 1, 104, 105, 127};
         int ml [10] = '{0, 1, 103, 104, 105, 106, 126, 127, 128, 255};
         foreach (tl[i]) begin
            foreach (ml[j]) begin
               for (int h = 0; h < 2; h++) begin
                  for (int s = 0; s < 2; s++) begin
                     logic [15:0] w;
                     bit exp_hit;
                     do_reset();
                     wr(mkc(1, tl[i], tl[i], tl[i]));
                     w = mkw(ml[j], h[0], s[0]);
                     exp_hit = half_val(w) > 2 * tl[i];
                     heat(w, w, w, w);
                     check("R1 R3 R9 sweep src", {28'b0, trip_src}, {28'b0, {4{exp_hit}}});
                     check("R6 sweep flag", {31'b0, trip}, {31'b0, exp_hit});
                  end
               end
            end
         end
      end

      // R3 equality and half above
      do_reset(); wr(mkc(1, 105, 105, 105));
      heat(mkw(105,0,0), 0, 0, 0);
      check("R3 equal no trip", {28'b0, trip_src}, 0);
      heat(mkw(105,1,0), 0, 0, 0);
      check("R3 half above trips", {28'b0, trip_src}, 4'b0001);

      // R9 negative zero vs 0 and -1
      do_reset(); wr(mkc(1, 0, 0, 0));
      heat(mkw(0,0,1), mkw(0,0,1), mkw(0,0,1), mkw(0,0,1));
      check("R9 neg zero vs 0", {28'b0, trip_src}, 0);
      do_reset(); wr(mkc(1, -1, -1, -1));
      heat(mkw(0,0,1), mkw(0,0,1), mkw(0,0,1), mkw(0,0,1));
      check("R9 neg zero vs -1", {28'b0, trip_src}, 4'b1111);

      // R2 R5 mapping with distinct limits gen=70 cpu=50 gm=60
      do_reset(); wr(mkc(1, 70, 50, 60));
      heat(mkw(65,0,0), mkw(65,0,0), mkw(65,0,0), mkw(65,0,0));
      check("R5 R2 65deg", {28'b0, trip_src}, 4'b0111);
      do_reset(); wr(mkc(1, 70, 50, 60));
      heat(mkw(55,0,0), mkw(55,0,0), mkw(55,0,0), mkw(55,0,0));
      check("R5 R2 55deg", {28'b0, trip_src}, 4'b0001);
      do_reset(); wr(mkc(1, 40, 100, 100));
      heat(mkw(45,0,0), mkw(45,0,0), mkw(45,0,0), mkw(45,0,0));
      check("R5 pll general limit", {28'b0, trip_src}, 4'b1000);
      do_reset(); wr(mkc(1, 100, 100, 100));
      heat(0, mkw(110,0,0), 0, 0);
      check("R6 gpu bit", {28'b0, trip_src}, 4'b0010);
      do_reset(); wr(mkc(1, 100, 100, 100));
      heat(0, 0, mkw(110,0,0), 0);
      check("R6 mem bit", {28'b0, trip_src}, 4'b0100);

      // R7 sticky and accumulate, R4 disable
      heat(0, 0, 0, 0);
      @(negedge clk); @(negedge clk);
      check("R7 sticky after cool", {28'b0, trip_src}, 4'b0100);
      check("R7 flag sticky", {31'b0, trip}, 1);
      heat(mkw(120,0,0), 0, 0, 0);
      check("R7 accumulate", {28'b0, trip_src}, 4'b0101);
      wr(mkc(0, 100, 100, 100));
      heat(0, 0, 0, mkw(120,0,0));
      @(negedge clk);
      check("R4 disabled keeps bits", {28'b0, trip_src}, 4'b0101);
      do_reset();
      check("R7 reset clears", {28'b0, trip_src}, 0);

      // R4 other bits set but enable clear
      wr(32'hEF00_0000 | mkc(0, 10, 10, 10));
      heat(mkw(90,0,0), mkw(90,0,0), mkw(90,0,0), mkw(90,0,0));
      check("R4 only bit 28 enables", {28'b0, trip_src}, 0);
      // R2 readback of reserved bits
      wr(32'hFFFF_FFFF);
      check("R2 reserved read zero", cfg_rdata, 32'h10FF_FFFF);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule